// File: doc/BRIEF.md
# Link-Layer Receive Sequence and Integrity Checker

This block sits on the receive side of a packet link layer. Frames arrive one byte per cycle. Each frame has a two-byte sequence header, a payload and a trailing 32-bit CRC. The block checks the frame's integrity and whether its sequence number is in order. It keeps the payload bytes in a local store until the verdict is known. A frame that passes is then streamed upward with the header and CRC stripped off, so a corrupted byte never reaches the consumer.

For every verdict that needs an answer, the block raises a one-cycle request toward the transmit side. The request says whether the answer is a positive or a negative acknowledgment and gives the sequence number it concerns. An acknowledgment covers that number and every number before it.

After an error, only one negative acknowledgment is sent. Frames that follow are discarded quietly until the transmitter's replay brings the expected number again. A stale, already-accepted frame is dropped and re-acknowledged.

Top module: `llr_rx_ackchk`

## Requirements
- R1: Frame layout, byte 0 first. Bytes 0 and 1 hold a big-endian 16-bit field, of which only the low SEQ_W bits are the sequence number; the upper bits are ignored. Next come 1 to MAX_PAY payload bytes. The frame ends with 4 CRC bytes, most significant first. The CRC is computed over header and payload with polynomial 0x04C11DB7, an initial value of all ones, MSB-first bit order, no reflection and no final inversion.
- R2: From the cycle after the last byte of a frame is accepted, `in_ready` is low until the verdict is made and any forwarding is complete. No byte is accepted while `up_valid` is high.
- R3: A good frame has a correct CRC, a payload length in range and a sequence number equal to the expected one. Its payload appears on `up_data` with `up_valid` high on consecutive cycles, in arrival order. The first byte appears in the second cycle after the last input byte is accepted, and `up_last` marks the final byte.
- R4: A good frame raises a positive request naming its own sequence number, in the same cycle as its first forwarded byte. The expected number then advances by one, modulo 2^SEQ_W.
- R5: A frame with a CRC mismatch, fewer than 7 bytes, or more than MAX_PAY payload bytes is dropped, and nothing is forwarded. If no negative request is outstanding, a negative request names the expected number minus one.
- R6: A frame whose sequence number is ahead of the expected one is treated like R5. "Ahead" means (expected − seq) mod 2^SEQ_W is greater than 2^(SEQ_W−1).
- R7: Only one negative request is raised per error episode. Later bad frames raise no request. The episode closes only when a good frame is accepted, and after that a new error raises a new negative request.
- R8: A frame with a correct CRC and length whose (expected − seq) mod 2^SEQ_W lies in 1..2^(SEQ_W−1) is a duplicate. It is dropped and raises a positive request naming the expected number minus one. It does not close an open error episode.
- R9: After reset, the expected number is 0, `in_ready` is high, and `up_valid` and `ack_req_valid` are low. A negative request before any good frame therefore names 2^SEQ_W − 1.
- R10: `ack_req_valid` is a single-cycle pulse, raised at most once per frame, in the second cycle after the frame's last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last byte of its frame |
| in_ready | output | 1 | Block can accept a byte this cycle |
| up_valid | output | 1 | Forwarded payload byte present |
| up_data | output | 8 | Forwarded payload byte |
| up_last | output | 1 | Final payload byte of the frame |
| ack_req_valid | output | 1 | Acknowledgment request pulse |
| ack_req_nak | output | 1 | 1 = negative, 0 = positive acknowledgment |
| ack_req_seq | output | SEQ_W | Sequence number the request names |

## Verification
Several properties are watched on every cycle:
- a negative request is never repeated within an open episode;
- requests last one cycle;
- a forwarded burst is unbroken and starts together with a positive request;
- input is refused right after a frame ends and throughout a burst.

Other behaviour is visible only in the bench's scenarios:
- the exact sequence number each request names;
- the payload bytes and their order;
- the treatment of stale versus future sequence numbers at the half-range boundary;
- masking of the upper header bits;
- the length limits.

// File: rtl/llr_pkg.sv
package llr_pkg;

    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam int          HDR_BYTES = 2;
    localparam int          CRC_BYTES = 4;

    typedef enum logic [1:0] {
        VERDICT_GOOD,
        VERDICT_DUP,
        VERDICT_BAD
    } verdict_e;

    // Summary of one completed frame, produced by the framer.
    typedef struct packed {
        logic        crc_ok;
        logic        len_ok;
        logic [15:0] seq;
        logic [15:0] pay_len;
    } frame_sum_t;

    // One byte through an MSB-first CRC register with no reflection.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] b);
        logic [31:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            if (c[31] ^ b[i]) c = (c << 1) ^ CRC_POLY;
            else              c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/llr_frame_rx.sv
module llr_frame_rx
    import llr_pkg::*;
#(
    parameter int SEQ_W   = 12,
    parameter int MAX_PAY = 64,
    localparam int BUF_D  = MAX_PAY + CRC_BYTES,
    localparam int AW     = $clog2(BUF_D)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done_q,
    output frame_sum_t    sum_q
);

    localparam logic [15:0] HDR16   = 16'(HDR_BYTES);
    localparam logic [15:0] OVH16   = 16'(HDR_BYTES + CRC_BYTES);
    localparam logic [15:0] MIN_TOT = 16'(HDR_BYTES + CRC_BYTES + 1);
    localparam logic [15:0] MAX_TOT = 16'(HDR_BYTES + MAX_PAY + CRC_BYTES);
    localparam logic [15:0] BUF16   = 16'(BUF_D);

    logic [15:0] cnt_q;
    logic [31:0] crc_q;
    logic [7:0]  hdr0_q, hdr1_q;
    logic [31:0] crc_nx;
    logic [15:0] body_idx;
    logic [15:0] total;

    // A running CRC taken over the appended CRC bytes as well leaves a zero residue.
    assign crc_nx   = crc32_step(crc_q, in_data);
    assign body_idx = cnt_q - HDR16;
    assign total    = cnt_q + 16'd1;

    // Everything after the header goes to the store; bytes past its depth are dropped (R5).
    assign wr_en   = acc && (cnt_q >= HDR16) && (body_idx < BUF16);
    assign wr_addr = AW'(body_idx);
    assign wr_data = in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            crc_q  <= CRC_SEED;
            hdr0_q <= '0;
            hdr1_q <= '0;
            done_q <= 1'b0;
            sum_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (acc) begin
                if (cnt_q == 16'd0) hdr0_q <= in_data;
                if (cnt_q == 16'd1) hdr1_q <= in_data;
                if (in_last) begin
                    done_q         <= 1'b1;
                    sum_q.crc_ok   <= (crc_nx == 32'd0);
                    sum_q.len_ok   <= (total >= MIN_TOT) && (total <= MAX_TOT);
                    sum_q.seq      <= {hdr0_q, hdr1_q};
                    sum_q.pay_len  <= total - OVH16;
                    cnt_q          <= '0;
                    crc_q          <= CRC_SEED;
                end else begin
                    cnt_q <= (cnt_q == 16'hFFFF) ? cnt_q : cnt_q + 16'd1;
                    crc_q <= crc_nx;
                end
            end
        end
    end

endmodule

// File: rtl/llr_seq_track.sv
module llr_seq_track
    import llr_pkg::*;
#(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  frame_sum_t       sum,
    output logic             start_drain,
    output logic [15:0]      drain_len,
    output logic             req_valid_q,
    output logic             req_nak_q,
    output logic [SEQ_W-1:0] req_seq_q
);

    localparam logic [SEQ_W-1:0] HALF = SEQ_W'(1) << (SEQ_W - 1);
    localparam logic [SEQ_W-1:0] ONE  = SEQ_W'(1);

    logic [SEQ_W-1:0] exp_q;
    logic             nak_sent_q;
    logic [SEQ_W-1:0] seq_c;
    logic [SEQ_W-1:0] diff;
    verdict_e         verdict;

    assign seq_c = SEQ_W'(sum.seq);   // upper header bits are ignored (R1)
    assign diff  = exp_q - seq_c;

    always_comb begin
        if (!(sum.crc_ok && sum.len_ok))         verdict = VERDICT_BAD;   // R5
        else if (diff == '0)                     verdict = VERDICT_GOOD;
        else if (diff <= HALF)                   verdict = VERDICT_DUP;   // R8
        else                                     verdict = VERDICT_BAD;   // R6: ahead
    end

    assign start_drain = done && (verdict == VERDICT_GOOD);
    assign drain_len   = sum.pay_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q       <= '0;
            nak_sent_q  <= 1'b0;
            req_valid_q <= 1'b0;
            req_nak_q   <= 1'b0;
            req_seq_q   <= '0;
        end else begin
            req_valid_q <= 1'b0;
            if (done) begin
                unique case (verdict)
                    VERDICT_GOOD: begin   // R4
                        req_valid_q <= 1'b1;
                        req_nak_q   <= 1'b0;
                        req_seq_q   <= seq_c;
                        exp_q       <= exp_q + ONE;
                        nak_sent_q  <= 1'b0;
                    end
                    VERDICT_DUP: begin
                        req_valid_q <= 1'b1;
                        req_nak_q   <= 1'b0;
                        req_seq_q   <= exp_q - ONE;
                    end
                    default: begin        // R7: one NAK per episode
                        if (!nak_sent_q) begin
                            req_valid_q <= 1'b1;
                            req_nak_q   <= 1'b1;
                            req_seq_q   <= exp_q - ONE;
                            nak_sent_q  <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/llr_pay_buf.sv
module llr_pay_buf
    import llr_pkg::*;
#(
    parameter int MAX_PAY = 64,
    localparam int BUF_D  = MAX_PAY + CRC_BYTES,
    localparam int AW     = $clog2(BUF_D)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic [15:0]   len,
    output logic          busy,
    output logic          up_valid,
    output logic [7:0]    up_data,
    output logic          up_last
);

    logic [7:0]    mem [BUF_D];
    logic          active_q;
    logic [AW-1:0] rd_q;
    logic [AW-1:0] end_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rd_q     <= '0;
            end_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            rd_q     <= '0;
            end_q    <= AW'(len - 16'd1);
        end else if (active_q) begin
            if (rd_q == end_q) active_q <= 1'b0;
            else               rd_q     <= rd_q + AW'(1);
        end
    end

    assign busy     = active_q;
    assign up_valid = active_q;
    assign up_data  = mem[rd_q];
    assign up_last  = active_q && (rd_q == end_q);

endmodule

// File: rtl/llr_rx_ackchk.sv
module llr_rx_ackchk
    import llr_pkg::*;
#(
    parameter int SEQ_W   = 12,
    parameter int MAX_PAY = 64,
    localparam int BUF_D  = MAX_PAY + CRC_BYTES,
    localparam int AW     = $clog2(BUF_D)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             up_valid,
    output logic [7:0]       up_data,
    output logic             up_last,
    output logic             ack_req_valid,
    output logic             ack_req_nak,
    output logic [SEQ_W-1:0] ack_req_seq
);

    logic          acc;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          done;
    frame_sum_t    sum;
    logic          start_drain;
    logic [15:0]   drain_len;
    logic          busy;

    // R2: hold input while a verdict or a forward is pending.
    assign in_ready = !done && !busy;
    assign acc      = in_valid && in_ready;

    llr_frame_rx #(.SEQ_W(SEQ_W), .MAX_PAY(MAX_PAY)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .in_data (in_data),
        .in_last (in_last),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done_q  (done),
        .sum_q   (sum)
    );

    llr_seq_track #(.SEQ_W(SEQ_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .sum         (sum),
        .start_drain (start_drain),
        .drain_len   (drain_len),
        .req_valid_q (ack_req_valid),
        .req_nak_q   (ack_req_nak),
        .req_seq_q   (ack_req_seq)
    );

    llr_pay_buf #(.MAX_PAY(MAX_PAY)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .start    (start_drain),
        .len      (drain_len),
        .busy     (busy),
        .up_valid (up_valid),
        .up_data  (up_data),
        .up_last  (up_last)
    );

endmodule

// File: rtl/llr_rx_ackchk_chk.sv
module llr_rx_ackchk_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic up_valid,
    input logic up_last,
    input logic ack_req_valid,
    input logic ack_req_nak
);

    // Open error episode as seen from the request stream alone.
    logic nak_open_q;
    always_ff @(posedge clk) begin
        if (rst)                                         nak_open_q <= 1'b0;
        else if (ack_req_valid && ack_req_nak)           nak_open_q <= 1'b1;
        else if (ack_req_valid && !ack_req_nak && up_valid) nak_open_q <= 1'b0;
    end

    a_r7_single_nak: assert property (@(posedge clk) disable iff (rst)
        (ack_req_valid && ack_req_nak) |-> !nak_open_q);

    a_r2_hold_after_last: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    a_r2_no_accept_drain: assert property (@(posedge clk) disable iff (rst)
        up_valid |-> !in_ready);

    a_r3_burst_contig: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_last) |=> up_valid);

    a_r4_ack_on_first: assert property (@(posedge clk) disable iff (rst)
        $rose(up_valid) |-> (ack_req_valid && !ack_req_nak));

    a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_req_valid |=> !ack_req_valid);

    a_r5_nak_no_fwd: assert property (@(posedge clk) disable iff (rst)
        (ack_req_valid && ack_req_nak) |-> !up_valid);

endmodule

bind llr_rx_ackchk llr_rx_ackchk_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_last       (in_last),
    .in_ready      (in_ready),
    .up_valid      (up_valid),
    .up_last       (up_last),
    .ack_req_valid (ack_req_valid),
    .ack_req_nak   (ack_req_nak)
);

// File: tb/sim_llr_rx_ackchk.sv
module sim_llr_rx_ackchk;

    localparam int SEQ_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_last = 1'b0;
    logic             in_ready;
    logic             up_valid;
    logic [7:0]       up_data;
    logic             up_last;
    logic             ack_req_valid;
    logic             ack_req_nak;
    logic [SEQ_W-1:0] ack_req_seq;

    always #5 clk = ~clk;   // 100 MHz

    llr_rx_ackchk #(.SEQ_W(SEQ_W), .MAX_PAY(64)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .up_valid(up_valid), .up_data(up_data), .up_last(up_last),
        .ack_req_valid(ack_req_valid), .ack_req_nak(ack_req_nak), .ack_req_seq(ack_req_seq)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor state, cleared by run_case before each frame.
    int         req_cnt, req_cyc, up_cnt, first_cyc, last_idx, data_err;
    logic       req_nak;
    logic [11:0] req_seq;
    logic [7:0] exp_pay [80];
    int         fidx = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ack_req_valid) begin
                req_cnt++;
                req_cyc = cyc;
                req_nak = ack_req_nak;
                req_seq = ack_req_seq;
            end
            if (up_valid) begin
                if (up_cnt == 0) first_cyc = cyc;
                if (up_cnt < 80 && up_data !== exp_pay[up_cnt]) data_err++;
                if (up_last) last_idx = up_cnt;
                up_cnt++;
            end
        end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_sim();
    end

    task automatic check(input bit ok, input int tag, input string what, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [7:0] b);
        logic [31:0] c;
        c = c0;
        for (int k = 0; k < 8; k++) begin
            logic top;
            top = c[31] ^ b[7-k];
            c = {c[30:0], 1'b0};
            if (top) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    // Sends one frame (R1 layout) and checks requests and forwarding.
    // req: 0 none, 1 positive, 2 negative.
    task automatic run_case(input logic [15:0] seq, input int len, input bit bad,
                            input int req, input int rseq, input bit fwd, input int tag);
        logic [7:0]  fr [80];
        logic [31:0] crc;
        int          nb, acc_cyc;
        fidx++;
        fr[0] = seq[15:8];
        fr[1] = seq[7:0];
        for (int i = 0; i < len; i++) begin
            fr[2+i]    = 8'((fidx * 31 + i * 7 + 3) & 255);
            exp_pay[i] = fr[2+i];
        end
        crc = 32'hFFFFFFFF;
        for (int i = 0; i < len + 2; i++) crc = ref_crc(crc, fr[i]);
        fr[len+2] = crc[31:24];
        fr[len+3] = crc[23:16];
        fr[len+4] = crc[15:8];
        fr[len+5] = crc[7:0];
        if (bad) fr[len+5] = fr[len+5] ^ 8'h01;
        nb = len + 6;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        req_cnt = 0; up_cnt = 0; data_err = 0; last_idx = -1; first_cyc = -1; req_cyc = -1;
        for (int i = 0; i < nb; i++) begin
            in_valid = 1'b1;
            in_data  = fr[i];
            in_last  = (i == nb - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        acc_cyc  = cyc;
        check(in_ready == 1'b0, 2, "ready after last byte", longint'(in_ready), 0);
        repeat (len + 6) @(negedge clk);
        check(req_cnt == ((req != 0) ? 1 : 0), (req == 0) ? 7 : 10, "request count", req_cnt, (req != 0) ? 1 : 0);
        if (req != 0) begin
            check(req_nak == (req == 2), tag, "request kind", longint'(req_nak), (req == 2) ? 1 : 0);
            check(int'(req_seq) == rseq, tag, "request seq", longint'(req_seq), rseq);
            check(req_cyc == acc_cyc + 1, 10, "request cycle", req_cyc - acc_cyc, 1);
        end
        check(up_cnt == (fwd ? len : 0), fwd ? 3 : 5, "forwarded bytes", up_cnt, fwd ? len : 0);
        if (fwd) begin
            check(data_err == 0, 3, "payload mismatches", data_err, 0);
            check(last_idx == len - 1, 3, "last marker index", last_idx, len - 1);
            check(first_cyc == acc_cyc + 1, 3, "first byte cycle", first_cyc - acc_cyc, 1);
            check(req_cyc == first_cyc, 4, "ACK with first byte", req_cyc, first_cyc);
        end
    endtask

    typedef struct packed {
        logic [15:0] seq;
        logic [7:0]  len;
        logic        bad;
        logic [1:0]  req;
        logic [11:0] rseq;
        logic        fwd;
        logic [3:0]  tag;
    } vec_t;

    // R1 R3 R4 R5 R6 R7 R8 scenarios in order; expected number starts at 0.
    localparam vec_t TBL [13] = '{
        '{16'h0000, 8'd4,  1'b0, 2'd1, 12'd0, 1'b1, 4'd3},
        '{16'h0001, 8'd1,  1'b0, 2'd1, 12'd1, 1'b1, 4'd4},
        '{16'h0002, 8'd64, 1'b0, 2'd1, 12'd2, 1'b1, 4'd3},
        '{16'h0003, 8'd8,  1'b1, 2'd2, 12'd2, 1'b0, 4'd5},
        '{16'h0004, 8'd5,  1'b0, 2'd0, 12'd0, 1'b0, 4'd7},
        '{16'h0001, 8'd3,  1'b0, 2'd1, 12'd2, 1'b0, 4'd8},
        '{16'h0003, 8'd6,  1'b0, 2'd1, 12'd3, 1'b1, 4'd7},
        '{16'h0009, 8'd2,  1'b0, 2'd2, 12'd3, 1'b0, 4'd6},
        '{16'h0004, 8'd0,  1'b0, 2'd0, 12'd0, 1'b0, 4'd5},
        '{16'h0004, 8'd2,  1'b0, 2'd1, 12'd4, 1'b1, 4'd4},
        '{16'h0005, 8'd65, 1'b0, 2'd2, 12'd4, 1'b0, 4'd5},
        '{16'h0005, 8'd3,  1'b0, 2'd1, 12'd5, 1'b1, 4'd3},
        '{16'hF006, 8'd2,  1'b0, 2'd1, 12'd6, 1'b1, 4'd1}
    };

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: state held during reset
        check(in_ready == 1'b1, 9, "ready in reset", longint'(in_ready), 1);
        check(up_valid == 1'b0, 9, "up_valid in reset", longint'(up_valid), 0);
        check(ack_req_valid == 1'b0, 9, "request in reset", longint'(ack_req_valid), 0);
        rst = 1'b0;

        for (int v = 0; v < 13; v++) begin
            run_case(TBL[v].seq, int'(TBL[v].len), TBL[v].bad, int'(TBL[v].req),
                     int'(TBL[v].rseq), TBL[v].fwd, int'(TBL[v].tag));
        end

        // R9: reset mid-run restores expected number 0
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_case(16'd5, 3, 1'b0, 2, 4095, 1'b0, 9);   // NAK names all ones
        run_case(16'd0, 2, 1'b0, 1, 0, 1'b1, 9);      // closes episode, expected 1
        // R8 boundary: 1 - 2049 = 2048 = half range -> duplicate
        run_case(16'd2049, 2, 1'b0, 1, 0, 1'b0, 8);
        // R6 boundary: 1 - 2048 = 2049 -> ahead
        run_case(16'd2048, 2, 1'b0, 2, 0, 1'b0, 6);

        finish_sim();
    end

endmodule